// File: doc/BRIEF.md
# Strap-Addressed Register-Pointer Bus Target

This block is a two-wire serial bus target (SMBus/I2C write protocol) that gives a bus master write access to a 256-entry by 8-bit register file. It runs entirely from a fast system clock. The SCL and SDA lines are synchronised and oversampled. START and STOP are recognised from SDA edges while SCL is high. Acknowledge bits are sent by pulling SDA low through an open-drain output enable.

The device address is chosen by a strap input, and the strap is not hard-wired. The block captures the strap level while reset is asserted and picks one of two unrelated 7-bit addresses. After reset the strap pin can serve another function, and its later changes are ignored. A write carries three bytes:

1. The address byte with the direction bit clear.
2. A byte that loads the internal register pointer.
3. A data byte that is stored at the register the pointer names.

Each completed register write also appears for one cycle on a strobe output, together with its index and data. The stored contents can be inspected through a combinational read port.

Top module: `smbr_strap_slave`

## Requirements
- R1: With `strap_i` low while reset is asserted, the block answers to 7-bit address 0x4E, which is address byte 0x9C with the direction bit (bit 0) clear.
- R2: With `strap_i` high while reset is asserted, the block answers to 7-bit address 0x37, which is address byte 0x6E, and it does not answer to 0x4E.
- R3: The strap is captured only while `rst_n` is low. Changing `strap_i` after reset has no effect on which address is answered.
- R4: For a matching address byte, `sda_oe_o` is high during the whole ninth SCL clock. For a non-matching address, `sda_oe_o` stays low, and the following bytes are neither acknowledged nor written until the next START.
- R5: The byte after an acknowledged address loads the register pointer and is acknowledged. The next byte is acknowledged and written to the register the pointer selects. `wr_stb_o` is high for exactly one clock, with `wr_idx_o` set to the pointer and `wr_dat_o` set to the data.
- R6: Bits are received most significant first: the first data bit on the bus lands in bit 7 of the stored byte.
- R7: A STOP or repeated START before a byte is complete abandons that byte. No register is written and no acknowledge is sent. A repeated START begins a new address phase.
- R8: An address byte with the direction bit set (read request) is not acknowledged, and nothing is written.
- R9: Bytes sent after the data byte in the same transfer are not acknowledged and are not written.
- R10: After reset, `sda_oe_o` and `wr_stb_o` are low and every register reads zero.
- R11: `rd_dat_o` always shows the stored value of the register selected by `rd_idx_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset; the strap is captured while low |
| strap_i | input | 1 | Address select strap (low: 0x4E, high: 0x37) |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_oe_o | output | 1 | High pulls SDA low; SDA is never driven high |
| wr_stb_o | output | 1 | One-cycle strobe for each completed register write |
| wr_idx_o | output | 8 | Register index of the write being strobed |
| wr_dat_o | output | 8 | Data of the write being strobed |
| rd_idx_i | input | 8 | Register index for the inspection port |
| rd_dat_o | output | 8 | Contents of the register at `rd_idx_i` |

## Verification
The assertions assume a well-formed bus:
- SCL and SDA never change in the same system clock.
- SDA changes only while SCL is low, except for the START and STOP conditions.
- The master releases SDA during every ninth clock.
- Each SCL phase lasts longer than the synchroniser plus edge-detect latency of three clocks.
- The strap is steady over the last cycles of reset.

The bench models the bus as a wired-AND of the master's drive and the block's pull-down. It moves SCL and SDA only on separate falling system-clock edges, ten clocks apart, and changes data only in the SCL low phase. The abort cases break off a byte with a STOP or repeated START, which the assertions cover.

// File: rtl/smbr_pkg.sv
// Shared definitions for the strap-addressed register bus target.
// Assumes bytes on the bus are eight bits wide.
package smbr_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } smbr_state_e;
endpackage

// File: rtl/smbr_line_sync.sv
// Synchroniser and edge detector for one bus line.
// Assumes the line idles high; resets the pipeline to ones so no edge is
// reported after reset. Latency from pin to edge pulse is STAGES+1 clocks.
module smbr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES:0] pipe_q;

    // Shift the pin level through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-1:0], line_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] &  pipe_q[STAGES];
endmodule

// File: rtl/smbr_byte_fsm.sv
// Byte-level protocol engine: shifts bits in on SCL rise, decides on the
// acknowledge at the SCL fall after the eighth bit, and releases SDA at the
// fall that ends the ninth clock. Assumes start_i/stop_i are single pulses.
module smbr_byte_fsm
    import smbr_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_lvl_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [ADDR_W-1:0] dev_addr_i,
    output logic              sda_oe_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              idx_ld_o,
    output logic              wr_stb_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    smbr_state_e       state_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              full_q;
    logic              oe_q;
    logic              idx_ld_q;
    logic              wr_stb_q;

    // Sequence the transfer: bit capture, ACK decision, ACK release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            full_q    <= 1'b0;
            oe_q      <= 1'b0;
            idx_ld_q  <= 1'b0;
            wr_stb_q  <= 1'b0;
        end else begin
            idx_ld_q <= 1'b0;
            wr_stb_q <= 1'b0;
            if (start_i) begin
                state_q   <= ST_ADDR;
                bit_cnt_q <= '0;
                full_q    <= 1'b0;
                oe_q      <= 1'b0;
            end else if (stop_i) begin
                state_q <= ST_IDLE;
                full_q  <= 1'b0;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_INDEX, ST_DATA: begin
                        if (scl_rise_i && !full_q) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                            if (bit_cnt_q == CNT_W'(BYTE_W-1)) full_q <= 1'b1;
                        end else if (scl_fall_i && full_q) begin
                            full_q <= 1'b0;
                            if (state_q == ST_ADDR) begin
                                if (shreg_q[BYTE_W-1:1] == dev_addr_i && !shreg_q[0]) begin
                                    oe_q    <= 1'b1;
                                    state_q <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_IGNORE;
                                end
                            end else if (state_q == ST_INDEX) begin
                                oe_q     <= 1'b1;
                                idx_ld_q <= 1'b1;
                                state_q  <= ST_INDEX_ACK;
                            end else begin
                                oe_q     <= 1'b1;
                                wr_stb_q <= 1'b1;
                                state_q  <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_INDEX_ACK, ST_DATA_ACK: begin
                        if (scl_fall_i) begin
                            oe_q      <= 1'b0;
                            bit_cnt_q <= '0;
                            if (state_q == ST_ADDR_ACK)       state_q <= ST_INDEX;
                            else if (state_q == ST_INDEX_ACK) state_q <= ST_DATA;
                            else                              state_q <= ST_IGNORE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o = oe_q;
    assign byte_o   = shreg_q;
    assign idx_ld_o = idx_ld_q;
    assign wr_stb_o = wr_stb_q;

    AST_OE_RISES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !scl_lvl_i); // R4
    AST_SILENT_WHEN_IGNORING: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !oe_q && !wr_stb_q); // R4
    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !oe_q && !wr_stb_q); // R7
    AST_START_NEW_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> state_q == ST_ADDR && !oe_q); // R7
    AST_STB_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |=> !wr_stb_q); // R5
endmodule

// File: rtl/smbr_regfile.sv
// Register file with one write port and one combinational read port.
// Assumes a deterministic cleared state is wanted after reset.
module smbr_regfile #(
    parameter int IDX_W = 8,
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [DAT_W-1:0] wr_dat_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [DAT_W-1:0] rd_dat_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DAT_W-1:0] mem_q [DEPTH];

    // Clear on reset, otherwise store the strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_dat_i;
        end
    end

    assign rd_dat_o = mem_q[rd_idx_i];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_dat_i)); // R5
endmodule

// File: rtl/smbr_strap_slave.sv
// Top level: strap-selected address, bus line conditioning, START/STOP
// detection, register pointer and register file. Assumes SCL and SDA never
// change in the same clock and each SCL phase exceeds SYNC_STAGES+1 clocks.
module smbr_strap_slave
    import smbr_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter int              IDX_W       = 8,
    parameter logic [6:0]      ADDR_LO     = 7'h4E,
    parameter logic [6:0]      ADDR_HI     = 7'h37
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic              wr_stb_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_dat_o,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [BYTE_W-1:0] rd_dat_o
);
    localparam int N_LINES = 2;   // index 0: SCL, index 1: SDA

    logic [N_LINES-1:0] pins, lvl, rise, fall;
    logic               addr_sel_q;
    logic [6:0]         dev_addr;
    logic               start_det, stop_det;
    logic [BYTE_W-1:0]  rx_byte;
    logic               idx_ld;
    logic               wr_stb;
    logic [IDX_W-1:0]   ptr_q;

    assign pins = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        smbr_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (pins[g]),
            .level_o(lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    // Capture the strap while reset is held; keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) addr_sel_q <= strap_i;
    end

    assign dev_addr  = addr_sel_q ? ADDR_HI : ADDR_LO;
    assign start_det = lvl[0] & fall[1];
    assign stop_det  = lvl[0] & rise[1];

    smbr_byte_fsm #(.ADDR_W(7)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl_i (lvl[0]),
        .scl_rise_i(rise[0]),
        .scl_fall_i(fall[0]),
        .sda_lvl_i (lvl[1]),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .dev_addr_i(dev_addr),
        .sda_oe_o  (sda_oe_o),
        .byte_o    (rx_byte),
        .idx_ld_o  (idx_ld),
        .wr_stb_o  (wr_stb)
    );

    // Load the register pointer from each completed index byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (idx_ld) ptr_q <= rx_byte[IDX_W-1:0];
    end

    smbr_regfile #(.IDX_W(IDX_W), .DAT_W(BYTE_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_stb),
        .wr_idx_i(ptr_q),
        .wr_dat_i(rx_byte),
        .rd_idx_i(rd_idx_i),
        .rd_dat_o(rd_dat_o)
    );

    assign wr_stb_o = wr_stb;
    assign wr_idx_o = ptr_q;
    assign wr_dat_o = rx_byte;

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(addr_sel_q)); // R3
    AST_PTR_STILL_DURING_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !idx_ld && $stable(ptr_q)); // R5
endmodule

// File: tb/test_smbr_strap_slave.sv
module test_smbr_strap_slave;
    localparam int Q = 10;

    typedef struct packed {
        logic [7:0] idx;
        logic [7:0] dat;
    } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_oe, wr_stb;
    logic [7:0] wr_idx, wr_dat, rd_idx, rd_dat;
    logic       sda_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    wr_item_t exp_q[$];
    logic [7:0] model [256];

    always #4 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    smbr_strap_slave i_smbr_strap_slave (
        .clk(clk), .rst_n(rst_n), .strap_i(strap), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_dat_o(wr_dat),
        .rd_idx_i(rd_idx), .rd_dat_o(rd_dat)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the scoreboard on every write strobe.
    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected write", {wr_idx, wr_dat}, 0);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check({wr_idx, wr_dat} == {e.idx, e.dat}, "R5 write strobe",
                      {wr_idx, wr_dat}, {e.idx, e.dat});
            end
        end
    end

    task automatic do_reset(input logic s);
        strap = s;
        rst_n = 1'b0;
        wq(6);
        rst_n = 1'b1;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        wq(4);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit exp_ack, input string req);
        send_bits(v, 8);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q / 2);
        check(sda_oe == exp_ack, req, sda_oe, exp_ack);
        wq(Q / 2); m_scl = 1'b0; wq(Q);
    endtask

    // Driver: full write transfer; pushes the expected write when it is due.
    task automatic write_txn(input logic [7:0] abyte, input logic [7:0] idx,
                             input logic [7:0] dat, input bit match, input string req);
        bus_start;
        send_byte(abyte, match, req);
        send_byte(idx, match, req);
        if (match) begin
            exp_q.push_back('{idx: idx, dat: dat});
            model[idx] = dat;
        end
        send_byte(dat, match, req);
        bus_stop;
    endtask

    task automatic check_reg(input logic [7:0] idx, input string req);
        rd_idx = idx;
        wq(1);
        check(rd_dat == model[idx], req, rd_dat, model[idx]);
    endtask

    initial begin
        rd_idx = 8'h00;
        do_reset(1'b0);
        // R10: reset state
        check(sda_oe == 1'b0, "R10 oe after reset", sda_oe, 0);
        check(wr_stb == 1'b0, "R10 strobe after reset", wr_stb, 0);
        check_reg(8'h00, "R10 reg 0x00");
        check_reg(8'hFF, "R10 reg 0xFF");

        // R1 R4 R5: basic write with strap low
        write_txn(8'h9C, 8'h12, 8'hA5, 1'b1, "R1 ack low-strap address");
        check_reg(8'h12, "R5 reg 0x12");
        check_reg(8'h13, "R11 neighbour untouched");
        write_txn(8'h9C, 8'hFE, 8'h5A, 1'b1, "R5 second write");
        check_reg(8'hFE, "R11 reg 0xFE");

        // R6: MSB first
        write_txn(8'h9C, 8'h80, 8'h01, 1'b1, "R6 msb first");
        check_reg(8'h80, "R6 reg 0x80 holds 0x01");

        // R4: mismatched address is ignored
        write_txn(8'h6E, 8'h12, 8'h00, 1'b0, "R4 no ack for other address");
        check_reg(8'h12, "R4 reg 0x12 unchanged");

        // R8: read direction not acknowledged
        bus_start;
        send_byte(8'h9D, 1'b0, "R8 read request nack");
        send_byte(8'h12, 1'b0, "R8 following byte nack");
        bus_stop;
        check_reg(8'h12, "R8 reg 0x12 unchanged");

        // R7: STOP inside data byte
        bus_start;
        send_byte(8'h9C, 1'b1, "R7 address ack");
        send_byte(8'h30, 1'b1, "R7 index ack");
        send_bits(8'hFF, 4);
        bus_stop;
        check_reg(8'h30, "R7 reg 0x30 not written");

        // R7: repeated START inside index byte, then a good transfer
        bus_start;
        send_byte(8'h9C, 1'b1, "R7 address ack before abort");
        send_bits(8'h31, 3);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
        send_byte(8'h9C, 1'b1, "R7 address ack after repeated start");
        send_byte(8'h31, 1'b1, "R7 index ack after repeated start");
        exp_q.push_back('{idx: 8'h31, dat: 8'h77});
        model[8'h31] = 8'h77;
        send_byte(8'h77, 1'b1, "R7 data ack after repeated start");
        bus_stop;
        check_reg(8'h31, "R7 reg 0x31");

        // R9: extra byte after data
        bus_start;
        send_byte(8'h9C, 1'b1, "R9 address ack");
        send_byte(8'h40, 1'b1, "R9 index ack");
        exp_q.push_back('{idx: 8'h40, dat: 8'h11});
        model[8'h40] = 8'h11;
        send_byte(8'h11, 1'b1, "R9 data ack");
        send_byte(8'h22, 1'b0, "R9 extra byte nack");
        bus_stop;
        check_reg(8'h40, "R9 reg 0x40");
        check_reg(8'h41, "R9 reg 0x41 untouched");

        // R3: strap change after reset has no effect
        strap = 1'b1;
        wq(4);
        write_txn(8'h6E, 8'h50, 8'h99, 1'b0, "R3 high address still ignored");
        write_txn(8'h9C, 8'h50, 8'h66, 1'b1, "R3 low address still answered");
        check_reg(8'h50, "R3 reg 0x50");

        // R2: strap high at reset
        do_reset(1'b1);
        check_reg(8'h12, "R10 reg 0x12 cleared");
        write_txn(8'h6E, 8'h05, 8'h3C, 1'b1, "R2 ack high-strap address");
        write_txn(8'h9C, 8'h05, 8'hC3, 1'b0, "R2 low address ignored");
        check_reg(8'h05, "R2 reg 0x05");
        strap = 1'b0;
        wq(4);
        write_txn(8'h6E, 8'h06, 8'hE1, 1'b1, "R3 strap drop ignored");
        check_reg(8'h06, "R3 reg 0x06");

        wq(20);
        check(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule